// File: doc/BRIEF.md
# Interrupt Priority and In-Service Tracker

This block is the decision core of an eight-line interrupt controller. It keeps three registers: pending requests, the programmed mask and the in-service set. From them it forms an interrupt output whenever some request is allowed to reach the processor. When an acknowledge strobe arrives, the block answers in the same cycle with the winning line number. In the next cycle it records that line as in service.

Line 0 has the highest priority. An in-service line blocks itself and every line with a larger index until an end-of-interrupt command retires it. Requests can be caught on rising edges or followed as levels. In-service bits can be retired by explicit commands, or automatically at acknowledge time. The surrounding register-programming logic supplies the initialization words, the mask writes and the end-of-interrupt commands through plain strobes.

Top module: `irq_prio_core`

## Requirements
- R1: After reset, pending and in-service are 0x00, the programmed mask is 0xFF and the interrupt output is low.
- R2: In edge mode, a 0-to-1 transition of a request input sets its pending bit on the next clock. A request that stays high does not set the bit again once it has been cleared.
- R3: In level mode (bit 3 of the initialization word is 1), each pending bit follows its request input. An accepted line keeps its pending bit while its input stays high, and the bit clears when the input drops.
- R4: The interrupt output is high exactly when some line is pending, unmasked and not priority-blocked. A programmed mask bit of 1 blocks its line.
- R5: While the acknowledge strobe is high, the acknowledge-valid output and a 3-bit line index are returned in the same cycle. The index names the lowest-numbered eligible line. Valid stays low when no line is eligible.
- R6: A line is not eligible while any in-service bit at its own index or a lower index is set.
- R7: An accepted line's in-service bit is set on the next clock. In edge mode, its pending bit is cleared at the same time.
- R8: An end-of-interrupt command whose bits [7:5] are not 011 clears only the lowest-numbered set in-service bit.
- R9: An end-of-interrupt command with bits [7:5] equal to 011 clears the in-service bit selected by bits [2:0].
- R10: When bit 1 of the last-written auto-retire word is 1, an acknowledge leaves no in-service bit set.
- R11: An initialization strobe clears pending, in-service and the programmed mask on the next clock, and latches the trigger mode. A request that is already high at that moment does not become pending in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Request inputs, index 0 highest priority |
| init_i | input | 1 | Initialization strobe |
| init_word_i | input | 8 | Initialization word; bit 3 selects level mode |
| aeoi_we_i | input | 1 | Write strobe for the auto-retire word |
| aeoi_word_i | input | 8 | Auto-retire word; bit 1 enables automatic retirement |
| mask_we_i | input | 1 | Programmed mask write strobe |
| mask_data_i | input | 8 | New programmed mask |
| eoi_i | input | 1 | End-of-interrupt command strobe |
| eoi_cmd_i | input | 8 | End-of-interrupt command code |
| ack_i | input | 1 | Acknowledge strobe |
| int_o | output | 1 | An eligible request exists |
| ack_valid_o | output | 1 | Acknowledge found a line |
| ack_line_o | output | 3 | Index of the acknowledged line |
| pend_o | output | 8 | Pending register |
| isr_o | output | 8 | In-service register |
| mask_o | output | 8 | Programmed mask register |

## Verification
A stale in-service bit shows at once as a line that raises no interrupt. The interrupt output stays low one cycle after the retiring command, even though `pend_o` holds an unmasked request. A wrong priority mask, or a wrong pick, appears in the same cycle as the acknowledge strobe, as a wrong index or a false valid. A pending bit that fails to clear, or to follow a level input, is visible on `pend_o` one clock after the acknowledge or after the input changes. The directed scenarios place each of these events so that the error shows within one or two cycles of its cause.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int CMD_W = 8;
    localparam logic [2:0] SPECIFIC_EOI_CODE = 3'b011;
    localparam int LEVEL_BIT = 3;
    localparam int AEOI_BIT  = 1;
endpackage

// File: rtl/irq_lowest_first.sv
module irq_lowest_first #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // taken[k]: some bit below k is set
    logic [N:0] taken;
    logic [N-1:0][IW-1:0] part;

    assign taken[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_scan
            assign taken[k+1] = taken[k] | vec_i[k];
            if (k == 0) begin : g_first
                assign part[k] = '0;
            end else begin : g_next
                assign part[k] = (vec_i[k] && !taken[k]) ? IW'(k) : part[k-1];
            end
        end
    endgenerate

    assign found_o = taken[N];
    assign idx_o   = part[N-1];
endmodule

// File: rtl/irq_prio_mask.sv
module irq_prio_mask #(
    parameter int N = 8
) (
    input  logic [N-1:0] isr_i,
    output logic [N-1:0] block_o
);
    // a line is blocked when any in-service bit at or below it is set
    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_pref
            if (k == 0) begin : g_first
                assign block_o[k] = isr_i[0];
            end else begin : g_next
                assign block_o[k] = block_o[k-1] | isr_i[k];
            end
        end
    endgenerate
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_LINES-1:0]     irq_i,
    input  logic                   init_i,
    input  logic [irq_pkg::CMD_W-1:0] init_word_i,
    input  logic                   aeoi_we_i,
    input  logic [irq_pkg::CMD_W-1:0] aeoi_word_i,
    input  logic                   mask_we_i,
    input  logic [N_LINES-1:0]     mask_data_i,
    input  logic                   eoi_i,
    input  logic [irq_pkg::CMD_W-1:0] eoi_cmd_i,
    input  logic                   ack_i,
    output logic                   int_o,
    output logic                   ack_valid_o,
    output logic [IDX_W-1:0]       ack_line_o,
    output logic [N_LINES-1:0]     pend_o,
    output logic [N_LINES-1:0]     isr_o,
    output logic [N_LINES-1:0]     mask_o
);
    import irq_pkg::*;

    typedef struct packed {
        logic [N_LINES-1:0] pend;
        logic [N_LINES-1:0] isr;
        logic [N_LINES-1:0] imr;
        logic [N_LINES-1:0] prev;
        logic               level;
        logic               aeoi;
    } core_state_t;

    core_state_t st_q, st_d;

    logic [N_LINES-1:0] block_w;
    logic [N_LINES-1:0] elig_w;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;
    logic               svc_found;
    logic [IDX_W-1:0]   svc_idx;
    logic               level_now;
    logic               aeoi_now;

    irq_prio_mask #(.N(N_LINES)) i_block (
        .isr_i   (st_q.isr),
        .block_o (block_w)
    );

    assign elig_w = st_q.pend & ~st_q.imr & ~block_w;

    irq_lowest_first #(.N(N_LINES), .IW(IDX_W)) i_pick (
        .vec_i   (elig_w),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    irq_lowest_first #(.N(N_LINES), .IW(IDX_W)) i_svc (
        .vec_i   (st_q.isr),
        .found_o (svc_found),
        .idx_o   (svc_idx)
    );

    always_comb begin
        logic ack_hit;
        logic [N_LINES-1:0] isr_tmp;
        logic [N_LINES-1:0] pend_tmp;

        st_d    = st_q;
        ack_hit = ack_i && pick_found;

        // retire first, then record the new acceptance
        isr_tmp = st_q.isr;
        if (eoi_i) begin
            if (eoi_cmd_i[CMD_W-1 -: 3] == SPECIFIC_EOI_CODE) begin
                isr_tmp[eoi_cmd_i[IDX_W-1:0]] = 1'b0;
            end else if (svc_found) begin
                isr_tmp[svc_idx] = 1'b0;
            end
        end
        if (ack_hit && !st_q.aeoi) begin
            isr_tmp[pick_idx] = 1'b1;
        end

        if (st_q.level) begin
            pend_tmp = irq_i;
        end else begin
            pend_tmp = st_q.pend;
            if (ack_hit) begin
                pend_tmp[pick_idx] = 1'b0;
            end
            pend_tmp = pend_tmp | (irq_i & ~st_q.prev);
        end

        st_d.isr  = isr_tmp;
        st_d.pend = pend_tmp;
        st_d.prev = irq_i;

        if (mask_we_i) begin
            st_d.imr = mask_data_i;
        end
        if (aeoi_we_i) begin
            st_d.aeoi = aeoi_word_i[AEOI_BIT];
        end
        if (init_i) begin
            st_d.pend  = '0;
            st_d.isr   = '0;
            st_d.imr   = '0;
            st_d.level = init_word_i[LEVEL_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend  <= '0;
            st_q.isr   <= '0;
            st_q.imr   <= '1;
            st_q.prev  <= '0;
            st_q.level <= 1'b0;
            st_q.aeoi  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_o       = pick_found;
    assign ack_valid_o = ack_i && pick_found;
    assign ack_line_o  = pick_idx;
    assign pend_o      = st_q.pend;
    assign isr_o       = st_q.isr;
    assign mask_o      = st_q.imr;
    assign level_now   = st_q.level;
    assign aeoi_now    = st_q.aeoi;
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk #(
    parameter int N_LINES = 8,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               init_i,
    input logic               eoi_i,
    input logic [7:0]         eoi_cmd_i,
    input logic               ack_i,
    input logic               ack_valid_o,
    input logic [IDX_W-1:0]   ack_line_o,
    input logic [N_LINES-1:0] pend_o,
    input logic [N_LINES-1:0] isr_o,
    input logic [N_LINES-1:0] mask_o,
    input logic               aeoi_now
);
    logic [N_LINES-1:0] at_or_below;
    always_comb begin
        for (int k = 0; k < N_LINES; k++) begin
            at_or_below[k] = (k <= int'(ack_line_o));
        end
    end

    // R5: a granted line was pending and unmasked
    p_grant_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> (pend_o[ack_line_o] && !mask_o[ack_line_o]));

    // R6: nothing at or above the granted priority is in service
    p_grant_unblocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> ((isr_o & at_or_below) == '0));

    // R5: valid only during the strobe
    p_valid_needs_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> ack_i);

    // R7: grant recorded in service on the next clock
    p_grant_recorded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && !aeoi_now && !init_i) |=> isr_o[$past(ack_line_o)]);

    // R9: specific retirement clears the named bit
    p_specific_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && eoi_cmd_i[7:5] == 3'b011 && !ack_i) |=> !isr_o[$past(eoi_cmd_i[IDX_W-1:0])]);

    // R11: initialization empties the registers
    p_init_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (pend_o == '0 && isr_o == '0 && mask_o == '0));

    // R10: auto retirement leaves nothing new in service
    p_auto_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && aeoi_now && !eoi_i && !init_i) |=> (isr_o == $past(isr_o)));
endmodule

bind irq_prio_core irq_prio_core_chk #(.N_LINES(N_LINES), .IDX_W(IDX_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .eoi_i       (eoi_i),
    .eoi_cmd_i   (eoi_cmd_i),
    .ack_i       (ack_i),
    .ack_valid_o (ack_valid_o),
    .ack_line_o  (ack_line_o),
    .pend_o      (pend_o),
    .isr_o       (isr_o),
    .mask_o      (mask_o),
    .aeoi_now    (aeoi_now)
);

// File: tb/test_irq_prio_core.sv
module test_irq_prio_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_i = '0;
    logic       init_i = 1'b0;
    logic [7:0] init_word_i = '0;
    logic       aeoi_we_i = 1'b0;
    logic [7:0] aeoi_word_i = '0;
    logic       mask_we_i = 1'b0;
    logic [7:0] mask_data_i = '0;
    logic       eoi_i = 1'b0;
    logic [7:0] eoi_cmd_i = '0;
    logic       ack_i = 1'b0;
    logic       int_o;
    logic       ack_valid_o;
    logic [2:0] ack_line_o;
    logic [7:0] pend_o;
    logic [7:0] isr_o;
    logic [7:0] mask_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_prio_core i_irq_prio_core (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
        .init_i(init_i), .init_word_i(init_word_i),
        .aeoi_we_i(aeoi_we_i), .aeoi_word_i(aeoi_word_i),
        .mask_we_i(mask_we_i), .mask_data_i(mask_data_i),
        .eoi_i(eoi_i), .eoi_cmd_i(eoi_cmd_i), .ack_i(ack_i),
        .int_o(int_o), .ack_valid_o(ack_valid_o), .ack_line_o(ack_line_o),
        .pend_o(pend_o), .isr_o(isr_o), .mask_o(mask_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_init(input logic [7:0] w);
        init_word_i = w; init_i = 1'b1;
        tick();
        init_i = 1'b0;
    endtask

    task automatic do_ack(input string req, input bit exp_valid, input int exp_line);
        ack_i = 1'b1;
        #1;
        check({req, " ack valid"}, ack_valid_o, exp_valid);
        if (exp_valid) check({req, " ack line"}, ack_line_o, exp_line);
        tick();
        ack_i = 1'b0;
    endtask

    task automatic do_eoi(input logic [7:0] cmd);
        eoi_cmd_i = cmd; eoi_i = 1'b1;
        tick();
        eoi_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pend", pend_o, 8'h00);
        check("R1 isr", isr_o, 8'h00);
        check("R1 mask", mask_o, 8'hFF);
        check("R1 int", int_o, 0);
    endtask

    task automatic t_edge_priority();
        do_init(8'h10);
        check("R11 mask after init", mask_o, 8'h00);
        irq_i = 8'h28;
        tick();
        check("R2 edge sets pend", pend_o, 8'h28);
        check("R4 int high", int_o, 1);
        do_ack("R5 pick 3", 1, 3);
        check("R7 isr set", isr_o, 8'h08);
        check("R7 edge pend cleared", pend_o, 8'h20);
        check("R6 line5 blocked", int_o, 0);
        do_ack("R6 no grant under 3", 0, 0);
        irq_i = 8'h2A;
        tick();
        check("R2 second edge", pend_o, 8'h22);
        check("R6 line1 above 3", int_o, 1);
        do_ack("R5 pick 1", 1, 1);
        check("R7 nested isr", isr_o, 8'h0A);
        do_eoi(8'h20);
        check("R8 lowest retired", isr_o, 8'h08);
        check("R6 still blocked", int_o, 0);
        do_eoi(8'h63);
        check("R9 specific retire", isr_o, 8'h00);
        check("R4 line5 eligible", int_o, 1);
        do_ack("R5 pick 5", 1, 5);
        check("R2 steady high no repend", pend_o, 8'h00);
        tick();
        check("R2 steady high later", pend_o, 8'h00);
        do_eoi(8'h65);
        check("R9 retire 5", isr_o, 8'h00);
        irq_i = 8'h00;
        tick();
    endtask

    task automatic t_mask();
        mask_data_i = 8'h04; mask_we_i = 1'b1;
        tick();
        mask_we_i = 1'b0;
        irq_i = 8'h04;
        tick();
        check("R4 masked pend", pend_o, 8'h04);
        check("R4 masked no int", int_o, 0);
        do_ack("R5 masked no grant", 0, 0);
        check("R4 masked isr untouched", isr_o, 8'h00);
        mask_data_i = 8'h00; mask_we_i = 1'b1;
        tick();
        mask_we_i = 1'b0;
        check("R4 unmasked int", int_o, 1);
        do_ack("R5 pick 2", 1, 2);
        do_eoi(8'h20);
        check("R8 retire 2", isr_o, 8'h00);
        irq_i = 8'h00;
        tick();
    endtask

    task automatic t_level();
        do_init(8'h18);
        irq_i = 8'h01;
        tick();
        check("R3 level pend", pend_o, 8'h01);
        do_ack("R3 pick 0", 1, 0);
        check("R3 pend kept", pend_o, 8'h01);
        check("R7 isr 0", isr_o, 8'h01);
        irq_i = 8'h00;
        tick();
        check("R3 drop clears", pend_o, 8'h00);
        do_eoi(8'h20);
        check("R8 retire 0", isr_o, 8'h00);
    endtask

    task automatic t_auto_and_init();
        aeoi_word_i = 8'h02; aeoi_we_i = 1'b1;
        tick();
        aeoi_we_i = 1'b0;
        do_init(8'h10);
        irq_i = 8'h40;
        tick();
        do_ack("R10 pick 6", 1, 6);
        check("R10 nothing in service", isr_o, 8'h00);
        check("R10 edge pend cleared", pend_o, 8'h00);
        aeoi_word_i = 8'h00; aeoi_we_i = 1'b1;
        tick();
        aeoi_we_i = 1'b0;
        irq_i = 8'h41;
        tick();
        do_ack("R11 setup pick 0", 1, 0);
        mask_data_i = 8'hF0; mask_we_i = 1'b1;
        tick();
        mask_we_i = 1'b0;
        check("R11 setup isr", isr_o, 8'h01);
        do_init(8'h10);
        check("R11 pend cleared", pend_o, 8'h00);
        check("R11 isr cleared", isr_o, 8'h00);
        check("R11 mask cleared", mask_o, 8'h00);
        tick();
        check("R11 held input not pending", pend_o, 8'h00);
        irq_i = 8'h00;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_edge_priority();
        t_mask();
        t_level();
        t_auto_and_init();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule